// File: doc/BRIEF.md
# Shared Adder-Subtractor with Magnitude Compare

A purely combinational unit that adds or subtracts two unsigned operands of a parameterised width on a single adder. When the mode input is low, the unit adds the operands. When the mode input is high, each bit of the second operand is inverted by an XOR stage, and the same mode bit enters the adder as its carry-in. The adder therefore computes A + ~B + 1, which is A - B modulo 2^N.

The N-bit result wraps. The bit that leaves the top of the adder is reported as a raw carry. In add mode this carry signals unsigned overflow. In subtract mode a carry of 1 means A is not below B, and a carry of 0 means A is below B.

Three compare outputs are decoded from only two signals: the subtraction carry and a zero flag on the result. These outputs are meaningful only while subtracting. In add mode they are held low. The zero flag is valid in both modes. The default width is 8 bits.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (A + B) mod 2^N.
- R2: With `sub_mode` = 0, `carry_out` is 1 exactly when A + B >= 2^N.
- R3: With `sub_mode` = 1, `result` equals (A - B) mod 2^N. The carry-in must follow the mode, so the result is never A - B - 1.
- R4: With `sub_mode` = 1, `carry_out` is 1 exactly when A >= B.
- R5: `zero` is 1 exactly when all N bits of `result` are 0, in either mode.
- R6: With `sub_mode` = 1, `a_gt_b` is 1 exactly when A > B, which is when the carry is 1 and the result is nonzero.
- R7: With `sub_mode` = 1, `a_eq_b` is 1 exactly when A == B, which is when the result is zero.
- R8: With `sub_mode` = 1, `a_lt_b` is 1 exactly when A < B, which is when the carry is 0.
- R9: With `sub_mode` = 0, `a_gt_b`, `a_eq_b` and `a_lt_b` are all 0.
- R10: With `sub_mode` = 1, exactly one of `a_gt_b`, `a_eq_b`, `a_lt_b` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand (minuend when subtracting) |
| op_b | input | WIDTH | Second unsigned operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Wrapped sum or difference |
| carry_out | output | 1 | Carry out of the top adder bit |
| zero | output | 1 | Result is all zeros |
| a_gt_b | output | 1 | A greater than B (subtract mode only) |
| a_eq_b | output | 1 | A equal to B (subtract mode only) |
| a_lt_b | output | 1 | A less than B (subtract mode only) |

## Verification
The in-module immediate assertions assume the inputs hold known 0/1 values. They skip any evaluation in which an operand or the mode is unknown. The bench drives every input from time zero with known values and changes them only between settled samples, so the assertions never see a half-updated or undefined vector. The stimulus sweeps every operand pair in both modes. This includes equal operands, zero operands, and all-ones wraparound.

// File: rtl/addsub_cmp.sv
module addsub_cmp #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero,
  output logic             a_gt_b,
  output logic             a_eq_b,
  output logic             a_lt_b
);

  localparam int SUMW = WIDTH + 1;

  logic [WIDTH-1:0] b_cond;
  logic [SUMW-1:0]  sum_full;

  assign b_cond    = op_b ^ {WIDTH{sub_mode}};
  assign sum_full  = {1'b0, op_a} + {1'b0, b_cond} + {{WIDTH{1'b0}}, sub_mode};
  assign result    = sum_full[WIDTH-1:0];
  assign carry_out = sum_full[WIDTH];
  assign zero      = ~|result;

  assign a_gt_b = sub_mode &  carry_out & ~zero;
  assign a_eq_b = sub_mode &  zero;
  assign a_lt_b = sub_mode & ~carry_out;

  always_comb begin
    if (!$isunknown({op_a, op_b, sub_mode})) begin
      if (!sub_mode) begin
        p_add_sum_r1: assert ({carry_out, result} == SUMW'(op_a) + SUMW'(op_b));
        p_add_nocmp_r9: assert ({a_gt_b, a_eq_b, a_lt_b} == 3'b000);
      end else begin
        p_sub_diff_r3: assert (result == WIDTH'(op_a - op_b));
        p_sub_carry_r4: assert (carry_out == (op_a >= op_b));
        p_sub_gt_r6: assert (a_gt_b == (op_a > op_b));
        p_sub_eq_r7: assert (a_eq_b == (op_a == op_b));
        p_sub_lt_r8: assert (a_lt_b == (op_a < op_b));
        p_sub_onehot_r10: assert ($countones({a_gt_b, a_eq_b, a_lt_b}) == 1);
      end
      p_zero_flag_r5: assert (zero == (result == '0));
    end
  end

endmodule

// File: tb/addsub_cmp_tb_top.sv
module addsub_cmp_tb_top;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic sub_mode, carry_out, zero, a_gt_b, a_eq_b, a_lt_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  addsub_cmp #(.WIDTH(W)) dut_i (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .result(result), .carry_out(carry_out), .zero(zero),
    .a_gt_b(a_gt_b), .a_eq_b(a_eq_b), .a_lt_b(a_lt_b)
  );

  task automatic chk(input string tag, input int act, input int exp, input int a, input int b, input int m);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d mode=%0d actual=%0d expected=%0d", tag, a, b, m, act, exp);
    end
  endtask

  initial begin
    op_a = '0; op_b = '0; sub_mode = 1'b0;
    @(posedge clk); #5;
    chk("R1 initial result", int'(result), 0, 0, 0, 0);
    chk("R5 initial zero", int'(zero), 1, 0, 0, 0);
    chk("R9 initial compares", int'({a_gt_b, a_eq_b, a_lt_b}), 0, 0, 0, 0);
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < M; a++) begin
        for (int b = 0; b < M; b++) begin
          @(posedge clk); #2;
          op_a = W'(a); op_b = W'(b); sub_mode = m[0];
          #6;
          if (m == 0) begin
            chk("R1 sum", int'(result), (a + b) % M, a, b, m);
            chk("R2 carry", int'(carry_out), (a + b >= M) ? 1 : 0, a, b, m);
            chk("R5 zero", int'(zero), ((a + b) % M == 0) ? 1 : 0, a, b, m);
            chk("R9 compares low", int'({a_gt_b, a_eq_b, a_lt_b}), 0, a, b, m);
          end else begin
            chk("R3 diff", int'(result), (a - b + M) % M, a, b, m);
            chk("R4 carry", int'(carry_out), (a >= b) ? 1 : 0, a, b, m);
            chk("R5 zero", int'(zero), (a == b) ? 1 : 0, a, b, m);
            chk("R6 gt", int'(a_gt_b), (a > b) ? 1 : 0, a, b, m);
            chk("R7 eq", int'(a_eq_b), (a == b) ? 1 : 0, a, b, m);
            chk("R8 lt", int'(a_lt_b), (a < b) ? 1 : 0, a, b, m);
            chk("R10 one compare", $countones({a_gt_b, a_eq_b, a_lt_b}), 1, a, b, m);
          end
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule